// File: doc/BRIEF.md
# Binary to decimal ASCII converter

This block turns an unsigned binary integer into the decimal text that represents it, written one byte at a time into a small character buffer through a byte-write port. A single-cycle start pulse hands the block a value. The block first writes a NUL terminator at a fixed end offset of the buffer. It then divides the value by ten over and over, and each remainder becomes one character, written at the next lower offset.

Repeated division gives the least significant digit first, so the text fills the buffer from its end towards its start. When the quotient reaches zero, the block raises a one-cycle done pulse. Alongside it the block gives the offset of the leading digit and the number of digits, so a reader can find the string in the buffer.

The divide-by-ten unit is a sequential restoring divider. It makes one quotient bit per clock cycle, so one digit costs a fixed number of cycles, however large the value is.

Top module: `dec_ascii_conv`

## Requirements
- R1: During and after reset, with no start seen, wr_en_o and done_o are 0, ndigits_o is 0 and first_addr_o is 10.
- R2: The first write after an accepted start goes to offset 10 with data 0x00, the NUL terminator, before any digit is written.
- R3: Each digit is written as its ASCII code, the digit value ORed with 0x30, so every digit byte lies in 0x30..0x39. Each write is a one-cycle strobe.
- R4: Digits are written least significant first, at offsets 9, 8, 7 and so on, each one below the previous write. For 2037 the writes are '7'@9, '3'@8, '0'@7, '2'@6.
- R5: An input of 0 produces exactly one digit, '0' (0x30), at offset 9, with a digit count of 1.
- R6: Conversion stops when the quotient is zero, so the digit count equals the number of decimal digits of the input. 4294967295 gives 10 digits, and the leading digit sits at offset 0.
- R7: After the last digit write, done_o pulses for one cycle with no write in that cycle. first_addr_o equals 10 minus ndigits_o. Both values hold until the next accepted start.
- R8: A start pulse that arrives while a conversion is running is ignored, and the running conversion completes with its original value.
- R9: While idle, no write strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| value_i | input | 32 | Unsigned value to convert, sampled with start |
| wr_en_o | output | 1 | Byte-write strobe |
| wr_addr_o | output | 4 | Buffer offset of the byte being written |
| wr_data_o | output | 8 | Byte being written (NUL or ASCII digit) |
| done_o | output | 1 | One-cycle completion pulse |
| first_addr_o | output | 4 | Offset of the most significant digit |
| ndigits_o | output | 4 | Number of digits written |

## Verification
The assertions assume that start_i is a clean pulse, and that value_i is stable in the cycle start is accepted. They also assume the buffer receives every strobe, because the address-step check tracks the previous write address itself. The directed tasks raise start for exactly one cycle away from the clock edge and hold value_i steady around it. The tasks wait for done before the next scenario, except for the one that deliberately fires a second start during a run, which the block must ignore.

// File: rtl/dac_pkg.sv
package dac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TERM,
    ST_LAUNCH,
    ST_WAIT,
    ST_EMIT,
    ST_FIN
  } conv_state_t;

  localparam logic [7:0] NUL_CHAR  = 8'h00;
  localparam logic [7:0] ZERO_CHAR = 8'h30;
  localparam int unsigned RADIX    = 10;

endpackage

// File: rtl/div10_seq.sv
// Restoring radix-2 divider by ten: one quotient bit per cycle.
module div10_seq #(
  parameter int unsigned VAL_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [VAL_W-1:0] dvd_i,
  output logic [VAL_W-1:0] quo_o,
  output logic [3:0]       rem_o,
  output logic             valid_o
);
  import dac_pkg::*;

  localparam int unsigned CNT_W = $clog2(VAL_W + 1);

  logic [VAL_W-1:0] work_q, work_d;
  logic [3:0]       rem_q, rem_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             fin_q, fin_d;

  logic [4:0] trial;
  logic [4:0] trial_sub;
  logic       fits;

  always_comb begin
    trial     = {rem_q, work_q[VAL_W-1]};
    fits      = (trial >= 5'(RADIX));
    trial_sub = fits ? (trial - 5'(RADIX)) : trial;
  end

  always_comb begin
    work_d = work_q;
    rem_d  = rem_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    fin_d  = 1'b0;
    if (go_i) begin
      work_d = dvd_i;
      rem_d  = 4'd0;
      cnt_d  = CNT_W'(VAL_W);
      run_d  = 1'b1;
    end else if (run_q) begin
      work_d = {work_q[VAL_W-2:0], fits};
      rem_d  = trial_sub[3:0];
      cnt_d  = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        run_d = 1'b0;
        fin_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      work_q <= work_d;
      rem_q  <= rem_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      fin_q  <= fin_d;
    end
  end

  assign quo_o   = work_q;
  assign rem_o   = rem_q;
  assign valid_o = fin_q;

endmodule

// File: rtl/digit_to_ascii.sv
// Maps a decimal digit onto its character code.
module digit_to_ascii (
  input  logic [3:0] digit_i,
  output logic [7:0] char_o
);
  import dac_pkg::*;

  assign char_o = ZERO_CHAR | {4'b0000, digit_i};

endmodule

// File: rtl/conv_ctrl.sv
// Sequencer: terminator, divide loop, backward address walk.
module conv_ctrl #(
  parameter int unsigned VAL_W      = 32,
  parameter int unsigned MAX_DIGITS = 10,
  parameter int unsigned ADDR_W     = $clog2(MAX_DIGITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [VAL_W-1:0]  value_i,
  output logic              div_go_o,
  output logic [VAL_W-1:0]  div_dvd_o,
  input  logic              div_valid_i,
  input  logic [VAL_W-1:0]  div_quo_i,
  output logic              wr_en_o,
  output logic              wr_digit_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] first_addr_o,
  output logic [ADDR_W-1:0] ndigits_o
);
  import dac_pkg::*;

  localparam logic [ADDR_W-1:0] END_ADDR = ADDR_W'(MAX_DIGITS);

  conv_state_t       state_q, state_d;
  logic [VAL_W-1:0]  val_q, val_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic              val_en;

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    cnt_d   = cnt_q;
    val_d   = val_q;
    val_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_TERM;
          val_d   = value_i;
          val_en  = 1'b1;
          ptr_d   = END_ADDR;
          cnt_d   = '0;
        end
      end
      ST_TERM:   state_d = ST_LAUNCH;
      ST_LAUNCH: state_d = ST_WAIT;
      ST_WAIT: begin
        if (div_valid_i) state_d = ST_EMIT;
      end
      ST_EMIT: begin
        ptr_d  = ptr_q - ADDR_W'(1);
        cnt_d  = cnt_q + ADDR_W'(1);
        val_d  = div_quo_i;
        val_en = 1'b1;
        state_d = (div_quo_i == '0) ? ST_FIN : ST_LAUNCH;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= END_ADDR;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (val_en) begin
      val_q <= val_d;
    end
  end

  always_comb begin
    div_go_o   = (state_q == ST_LAUNCH);
    div_dvd_o  = val_q;
    wr_en_o    = (state_q == ST_TERM) || (state_q == ST_EMIT);
    wr_digit_o = (state_q == ST_EMIT);
    wr_addr_o  = (state_q == ST_EMIT) ? (ptr_q - ADDR_W'(1)) : END_ADDR;
    done_o     = (state_q == ST_FIN);
  end

  assign first_addr_o = ptr_q;
  assign ndigits_o    = cnt_q;

endmodule

// File: rtl/dec_ascii_conv.sv
module dec_ascii_conv #(
  parameter int unsigned VAL_W      = 32,
  parameter int unsigned MAX_DIGITS = 10,
  parameter int unsigned ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [VAL_W-1:0]  value_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] first_addr_o,
  output logic [ADDR_W-1:0] ndigits_o
);
  import dac_pkg::*;

  logic             div_go;
  logic [VAL_W-1:0] div_dvd;
  logic [VAL_W-1:0] div_quo;
  logic [3:0]       div_rem;
  logic             div_valid;
  logic             wr_digit;
  logic [7:0]       digit_char;

  conv_ctrl #(
    .VAL_W     (VAL_W),
    .MAX_DIGITS(MAX_DIGITS),
    .ADDR_W    (ADDR_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .value_i     (value_i),
    .div_go_o    (div_go),
    .div_dvd_o   (div_dvd),
    .div_valid_i (div_valid),
    .div_quo_i   (div_quo),
    .wr_en_o     (wr_en_o),
    .wr_digit_o  (wr_digit),
    .wr_addr_o   (wr_addr_o),
    .done_o      (done_o),
    .first_addr_o(first_addr_o),
    .ndigits_o   (ndigits_o)
  );

  div10_seq #(
    .VAL_W(VAL_W)
  ) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (div_go),
    .dvd_i  (div_dvd),
    .quo_o  (div_quo),
    .rem_o  (div_rem),
    .valid_o(div_valid)
  );

  digit_to_ascii u_enc (
    .digit_i(div_rem),
    .char_o (digit_char)
  );

  assign wr_data_o = wr_digit ? digit_char : NUL_CHAR;

endmodule

// File: rtl/dec_ascii_conv_chk.sv
module dec_ascii_conv_chk #(
  parameter int unsigned MAX_DIGITS = 10,
  parameter int unsigned ADDR_W     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [7:0]        wr_data_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] first_addr_o,
  input logic [ADDR_W-1:0] ndigits_o
);
  localparam logic [ADDR_W-1:0] END_ADDR = ADDR_W'(MAX_DIGITS);

  logic [ADDR_W-1:0] last_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_addr_q <= END_ADDR;
    else if (wr_en_o) last_addr_q <= wr_addr_o;
  end

  a_r2_nul_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_addr_o == END_ADDR) |-> (wr_data_o == 8'h00));

  a_r3_digit_char: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_addr_o != END_ADDR) |->
      (wr_data_o[7:4] == 4'h3 && wr_data_o[3:0] <= 4'd9));

  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_addr_o != END_ADDR) |-> (wr_addr_o == last_addr_q - ADDR_W'(1)));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_done_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !wr_en_o);

  a_r7_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (first_addr_o == END_ADDR - ndigits_o));

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ndigits_o <= ADDR_W'(MAX_DIGITS));

endmodule

bind dec_ascii_conv dec_ascii_conv_chk #(
  .MAX_DIGITS(MAX_DIGITS),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en_o     (wr_en_o),
  .wr_addr_o   (wr_addr_o),
  .wr_data_o   (wr_data_o),
  .done_o      (done_o),
  .first_addr_o(first_addr_o),
  .ndigits_o   (ndigits_o)
);

// File: tb/sim_dec_ascii_conv.sv
module sim_dec_ascii_conv;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] value_i;
  logic        wr_en_o;
  logic [3:0]  wr_addr_o;
  logic [7:0]  wr_data_o;
  logic        done_o;
  logic [3:0]  first_addr_o;
  logic [3:0]  ndigits_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  logic [3:0] log_addr [0:31];
  logic [7:0] log_data [0:31];
  int         n_wr   = 0;
  int         n_done = 0;
  logic [3:0] done_first;
  logic [3:0] done_cnt;

  dec_ascii_conv u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .value_i     (value_i),
    .wr_en_o     (wr_en_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .done_o      (done_o),
    .first_addr_o(first_addr_o),
    .ndigits_o   (ndigits_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && wr_en_o) begin
      if (n_wr < 32) begin
        log_addr[n_wr] = wr_addr_o;
        log_data[n_wr] = wr_data_o;
      end
      n_wr = n_wr + 1;
    end
    if (rst_n && done_o) begin
      n_done     = n_done + 1;
      done_first = first_addr_o;
      done_cnt   = ndigits_o;
    end
  end

  always @(negedge clk) begin
    if (cycles > WATCHDOG) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic pulse_start(input logic [31:0] v);
    @(negedge clk);
    value_i = v;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input int base_done);
    for (int i = 0; i < 3000; i++) begin
      if (n_done > base_done) break;
      @(negedge clk);
    end
  endtask

  // Checks the full write trace and completion report for one value.
  task automatic verify(input logic [31:0] v, input string tag);
    logic [31:0] rest;
    int          nd;
    logic [7:0]  dig [0:9];
    rest = v;
    nd   = 0;
    do begin
      dig[nd] = 8'h30 | 8'(rest % 10);
      rest    = rest / 10;
      nd      = nd + 1;
    end while (rest != 0);
    check(n_wr == nd + 1, {tag, " R6 write count"}, n_wr, nd + 1);
    check(log_addr[0] == 4'd10 && log_data[0] == 8'h00, {tag, " R2 NUL first"},
          {log_addr[0], log_data[0]}, {4'd10, 8'h00});
    for (int i = 0; i < nd && i + 1 < 32; i++) begin
      check(log_addr[i+1] == 4'(9 - i), {tag, " R4 digit offset"}, log_addr[i+1], 9 - i);
      check(log_data[i+1] == dig[i], {tag, " R3 digit char"}, log_data[i+1], dig[i]);
    end
    check(n_done == 1, {tag, " R7 single done"}, n_done, 1);
    check(done_cnt == 4'(nd), {tag, " R6 digit count"}, done_cnt, nd);
    check(done_first == 4'(10 - nd), {tag, " R7 first offset"}, done_first, 10 - nd);
    check(first_addr_o == 4'(10 - nd) && ndigits_o == 4'(nd), {tag, " R7 held"},
          {first_addr_o, ndigits_o}, {4'(10 - nd), 4'(nd)});
  endtask

  task automatic run_conv(input logic [31:0] v, input string tag);
    n_wr   = 0;
    n_done = 0;
    pulse_start(v);
    wait_done(0);
    repeat (4) @(negedge clk);
    verify(v, tag);
  endtask

  task automatic t_reset;
    rst_n   = 1'b0;
    start_i = 1'b0;
    value_i = '0;
    repeat (3) @(negedge clk);
    check(!wr_en_o && !done_o, "R1 strobes in reset", {wr_en_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(ndigits_o == 4'd0, "R1 count after reset", ndigits_o, 0);
    check(first_addr_o == 4'd10, "R1 offset after reset", first_addr_o, 10);
    check(n_wr == 0 && n_done == 0, "R1 no activity", n_wr, 0);
  endtask

  task automatic t_2037;
    run_conv(32'd2037, "R4 2037");
  endtask

  task automatic t_zero;
    run_conv(32'd0, "R5 zero");
    check(log_data[1] == 8'h30 && log_addr[1] == 4'd9, "R5 zero char",
          {log_addr[1], log_data[1]}, {4'd9, 8'h30});
  endtask

  task automatic t_max;
    run_conv(32'hFFFF_FFFF, "R6 max");
    check(done_first == 4'd0, "R6 leading at 0", done_first, 0);
  endtask

  task automatic t_misc;
    run_conv(32'd9, "R3 nine");
    run_conv(32'd10, "R6 ten");
    run_conv(32'd1000000000, "R6 1e9");
    run_conv(32'd999999999, "R6 nines");
  endtask

  task automatic t_busy;
    n_wr   = 0;
    n_done = 0;
    pulse_start(32'd4321);
    repeat (20) @(negedge clk);
    pulse_start(32'd77);
    wait_done(0);
    repeat (4) @(negedge clk);
    verify(32'd4321, "R8 busy start");
  endtask

  task automatic t_idle;
    n_wr   = 0;
    n_done = 0;
    repeat (50) @(negedge clk);
    check(n_wr == 0, "R9 idle writes", n_wr, 0);
    check(n_done == 0, "R9 idle done", n_done, 0);
  endtask

  initial begin
    t_reset();
    t_2037();
    t_zero();
    t_max();
    t_misc();
    t_busy();
    t_idle();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule